// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block is an up-counting timer whose start, stop and clear are governed by a selectable trigger. A 3-bit mode setting ties the counter to the trigger in one of three ways. Restart clears the count on a trigger rising edge. Pause lets the counter run only while the trigger is high. Event arms the counter enable on a trigger rising edge. Any other mode value leaves the counter free-running under its own enable bit.

The trigger comes from a 3-bit source setting. The sources are four internal trigger lines, an any-edge pulse derived from channel 0, and the polarity-adjusted, filtered levels of channel 0 or channel 1. The channel inputs pass through a digital glitch filter with a run-length setting. The chosen trigger is then resynchronised and edge-detected, which gives a fixed latency before the counter reacts. The block keeps two sticky flags, one for trigger events and one for counter wraps, and each is cleared by a write-one strobe.

Top module: `tmr_slave_ctl`

## Requirements
- R1: After reset the counter is 0, the enable is 0 and both flags are 0.
- R2: With mode not 100, 101 or 110, the counter increments once per cycle while the enable is 1. When the count is at or above the reload value, the next count is 0 and the update flag (upd_flag_o) is set.
- R3: In mode 100 (restart), a rising edge of the selected trigger makes the counter 0 on the next cycle, whatever the enable, and sets the trigger flag. Counting then continues from 0.
- R4: In mode 101 (pause), the counter holds its value while the synchronised trigger is low. It counts, if enabled, while the trigger is high.
- R5: In mode 110 (event), a rising edge of the trigger sets the enable and wins over a simultaneous enable write. The enable stays set until it is written to 0.
- R6: Source codes 000 to 011 select internal trigger 0 to 3. Code 100 selects a one-cycle pulse on each rising or falling edge of filtered channel 0. Code 101 selects filtered channel 0, code 110 selects filtered channel 1, and code 111 gives a constant low trigger.
- R7: Polarity bit k (chan_pol_i[k]) inverts filtered channel k when source 101 (k=0) or 110 (k=1) is selected. The internal triggers are affected by neither polarity nor filter.
- R8: A trigger input change made just after a clock edge acts on the counter at the third following rising edge when the filter is bypassed. This latency comes from two resynchronising flops and an edge-detect flop.
- R9: A filter setting of 0 bypasses the filter. A setting s > 0 needs 2^(s-1) consecutive samples that differ from the filtered level before that level follows the input, so a shorter pulse has no effect.
- R10: Both flags are sticky until cleared by flag_clr_i (bit 0 clears the update flag, bit 1 clears the trigger flag). A set in the same cycle as a clear wins. The trigger flag is set by a trigger rising edge in modes 100, 101 and 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Slave mode setting |
| src_i | input | 3 | Trigger source setting |
| reload_i | input | CNT_W | Reload (wrap) value |
| flt_sel_i | input | FLT_W | Channel filter setting |
| chan_pol_i | input | 2 | Per-channel polarity inversion |
| int_trig_i | input | 4 | Internal trigger lines |
| chan_i | input | 2 | Channel inputs 0 and 1 |
| en_wr_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 1 | Enable write value |
| flag_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 update, bit 1 trigger |
| count_o | output | CNT_W | Counter value |
| en_o | output | 1 | Counter enable state |
| upd_flag_o | output | 1 | Sticky update (wrap) flag |
| trg_flag_o | output | 1 | Sticky trigger flag |

## Verification
The bench builds the block with CNT_W of 8 and the default FLT_W of 4. The short counter keeps the reload and wrap within a few cycles, and a reload of 200 keeps long trigger scenarios free of accidental wraps. The 4-bit filter setting lets a setting of 3 (run length 4) be tested against a 3-cycle glitch and a held level. It also shows that the internal triggers keep the 3-cycle latency while a non-zero filter setting is active.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam logic [2:0] MODE_RESTART = 3'b100;
   localparam logic [2:0] MODE_PAUSE   = 3'b101;
   localparam logic [2:0] MODE_EVENT   = 3'b110;

   localparam logic [2:0] SRC_CH0_EDGE = 3'b100;
   localparam logic [2:0] SRC_CH0      = 3'b101;
   localparam logic [2:0] SRC_CH1      = 3'b110;

   localparam int NUM_INT_TRIG = 4;
   localparam int NUM_CHAN     = 2;

   function automatic logic is_slave(input logic [2:0] m);
      return (m == MODE_RESTART) || (m == MODE_PAUSE) || (m == MODE_EVENT);
   endfunction
endpackage

// File: rtl/tsc_filter.sv
module tsc_filter #(
   parameter int FLT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLT_W-1:0] sel_i,
   input  logic             raw_i,
   output logic             lvl_o
);
   localparam int RUN_W = 1 << FLT_W;

   logic             bypass;
   logic             lvl_q;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] target;

   assign bypass = (sel_i == '0);
   assign target = RUN_W'(1) << (sel_i - FLT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         run_q <= '0;
      end else if (bypass) begin
         lvl_q <= raw_i;
         run_q <= '0;
      end else if (raw_i == lvl_q) begin
         run_q <= '0;
      end else if ((run_q + RUN_W'(1)) == target) begin
         lvl_q <= raw_i;
         run_q <= '0;
      end else begin
         run_q <= run_q + RUN_W'(1);
      end
   end

   assign lvl_o = bypass ? raw_i : lvl_q;

   assert_filter_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && (raw_i == lvl_q)) |=> (lvl_q == $past(lvl_q)));
endmodule

// File: rtl/tsc_trig.sv
module tsc_trig
   import tsc_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2:0]              src_i,
   input  logic [NUM_INT_TRIG-1:0] int_trig_i,
   input  logic [NUM_CHAN-1:0]     chan_flt_i,
   input  logic [NUM_CHAN-1:0]     chan_pol_i,
   output logic                    lvl_o,
   output logic                    rise_o
);
   logic ch0_q;
   logic ch0_edge;
   logic sel;
   logic sync1_q, sync2_q, edge_q;

   assign ch0_edge = chan_flt_i[0] ^ ch0_q;

   always_comb begin
      case (src_i)
         3'b000, 3'b001, 3'b010, 3'b011: sel = int_trig_i[src_i[1:0]];
         SRC_CH0_EDGE: sel = ch0_edge;
         SRC_CH0:      sel = chan_flt_i[0] ^ chan_pol_i[0];
         SRC_CH1:      sel = chan_flt_i[1] ^ chan_pol_i[1];
         default:      sel = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch0_q   <= 1'b0;
         sync1_q <= 1'b0;
         sync2_q <= 1'b0;
         edge_q  <= 1'b0;
      end else begin
         ch0_q   <= chan_flt_i[0];
         sync1_q <= sel;
         sync2_q <= sync1_q;
         edge_q  <= sync2_q;
      end
   end

   assign lvl_o  = sync2_q;
   assign rise_o = sync2_q & ~edge_q;
endmodule

// File: rtl/tsc_count.sv
module tsc_count
   import tsc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             en_wr_i,
   input  logic             en_wdata_i,
   input  logic             trig_lvl_i,
   input  logic             trig_rise_i,
   input  logic [1:0]       flag_clr_i,
   output logic [CNT_W-1:0] count_o,
   output logic             en_o,
   output logic             upd_o,
   output logic             trg_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             en_q, upd_q, trg_q;
   logic             restart, paused, active, wrap;
   logic             upd_set, trg_set;

   assign restart = (mode_i == MODE_RESTART) && trig_rise_i;
   assign paused  = (mode_i == MODE_PAUSE) && !trig_lvl_i;
   assign active  = en_q && !paused;
   assign wrap    = active && !restart && (cnt_q >= reload_i);
   assign upd_set = wrap;
   assign trg_set = is_slave(mode_i) && trig_rise_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
         upd_q <= 1'b0;
         trg_q <= 1'b0;
      end else begin
         if (restart || wrap)  cnt_q <= '0;
         else if (active)      cnt_q <= cnt_q + CNT_W'(1);

         if ((mode_i == MODE_EVENT) && trig_rise_i) en_q <= 1'b1;
         else if (en_wr_i)                          en_q <= en_wdata_i;

         upd_q <= upd_set | (upd_q & ~flag_clr_i[0]);
         trg_q <= trg_set | (trg_q & ~flag_clr_i[1]);
      end
   end

   assign count_o = cnt_q;
   assign en_o    = en_q;
   assign upd_o   = upd_q;
   assign trg_o   = trg_q;

   assert_restart_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == MODE_RESTART) && trig_rise_i) |=> ((cnt_q == '0) && trg_q));
   assert_wrap_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && (mode_i != MODE_PAUSE) && (mode_i != MODE_RESTART) && (cnt_q >= reload_i))
      |=> ((cnt_q == '0) && upd_q));
   assert_pause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == MODE_PAUSE) && !trig_lvl_i) |=> $stable(cnt_q));
   assert_event_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == MODE_EVENT) && trig_rise_i) |=> en_q);
   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_q && !flag_clr_i[0]) |=> upd_q);
endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
   import tsc_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int FLT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_i,
   input  logic [2:0]       src_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic [FLT_W-1:0] flt_sel_i,
   input  logic [1:0]       chan_pol_i,
   input  logic [3:0]       int_trig_i,
   input  logic [1:0]       chan_i,
   input  logic             en_wr_i,
   input  logic             en_wdata_i,
   input  logic [1:0]       flag_clr_i,
   output logic [CNT_W-1:0] count_o,
   output logic             en_o,
   output logic             upd_flag_o,
   output logic             trg_flag_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("tmr_slave_ctl: CNT_W must lie in 2..32");
   end
   if (FLT_W < 1 || FLT_W > 5) begin : g_bad_flt_w
      $error("tmr_slave_ctl: FLT_W must lie in 1..5");
   end

   logic [NUM_CHAN-1:0] chan_flt;
   logic                trig_lvl, trig_rise;

   for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
      tsc_filter #(.FLT_W(FLT_W)) i_filter (
         .clk   (clk),
         .rst_n (rst_n),
         .sel_i (flt_sel_i),
         .raw_i (chan_i[g]),
         .lvl_o (chan_flt[g])
      );
   end

   tsc_trig i_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i),
      .int_trig_i (int_trig_i),
      .chan_flt_i (chan_flt),
      .chan_pol_i (chan_pol_i),
      .lvl_o      (trig_lvl),
      .rise_o     (trig_rise)
   );

   tsc_count #(.CNT_W(CNT_W)) i_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .reload_i    (reload_i),
      .en_wr_i     (en_wr_i),
      .en_wdata_i  (en_wdata_i),
      .trig_lvl_i  (trig_lvl),
      .trig_rise_i (trig_rise),
      .flag_clr_i  (flag_clr_i),
      .count_o     (count_o),
      .en_o        (en_o),
      .upd_o       (upd_flag_o),
      .trg_o       (trg_flag_o)
   );
endmodule

// File: tb/test_tmr_slave_ctl.sv
module test_tmr_slave_ctl;
   localparam int CLK_P = 10;
   localparam int CW    = 8;
   localparam int FW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode = 3'b000;
   logic [2:0]    src = 3'b000;
   logic [CW-1:0] reload = CW'(200);
   logic [FW-1:0] flt = '0;
   logic [1:0]    pol = 2'b00;
   logic [3:0]    itrig = 4'h0;
   logic [1:0]    chan = 2'b00;
   logic          en_wr = 1'b0;
   logic          en_wd = 1'b0;
   logic [1:0]    fclr = 2'b00;
   logic [CW-1:0] count;
   logic          en, upd, trg;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;
   int v;

   always #(CLK_P/2) clk = ~clk;

   tmr_slave_ctl #(.CNT_W(CW), .FLT_W(FW)) i_tmr_slave_ctl (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .src_i(src), .reload_i(reload),
      .flt_sel_i(flt), .chan_pol_i(pol), .int_trig_i(itrig), .chan_i(chan),
      .en_wr_i(en_wr), .en_wdata_i(en_wd), .flag_clr_i(fclr),
      .count_o(count), .en_o(en), .upd_flag_o(upd), .trg_flag_o(trg)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic write_en(input logic val);
      en_wr = 1'b1; en_wd = val;
      tick(1);
      en_wr = 1'b0;
   endtask

   task automatic clear_flags(input logic [1:0] m);
      fclr = m;
      tick(1);
      fclr = 2'b00;
   endtask

   task automatic t_reset();
      chk("R1 count", int'(count), 0);
      chk("R1 enable", int'(en), 0);
      chk("R1 update flag", int'(upd), 0);
      chk("R1 trigger flag", int'(trg), 0);
   endtask

   task automatic t_wrap();
      mode = 3'b000; reload = CW'(5);
      write_en(1'b1);
      chk("R2 count after enable", int'(count), 0);
      tick(5);
      chk("R2 count at reload", int'(count), 5);
      chk("R2 no early update", int'(upd), 0);
      tick(1);
      chk("R2 wrap to 0", int'(count), 0);
      chk("R2 update flag", int'(upd), 1);
      clear_flags(2'b01);
      chk("R10 clear update", int'(upd), 0);
      tick(4);
      chk("R2 count again at reload", int'(count), 5);
      clear_flags(2'b01);
      chk("R10 set wins over clear", int'(upd), 1);
      clear_flags(2'b01);
      reload = CW'(200);
   endtask

   task automatic t_restart();
      mode = 3'b100; src = 3'b000; pol = 2'b11; flt = FW'(3);
      tick(20);
      clear_flags(2'b10);
      v = int'(count);
      itrig[0] = 1'b1;
      tick(2);
      chk("R8 no clear before third edge", int'(count), v + 2);
      tick(1);
      chk("R3 R7 restart clears count", int'(count), 0);
      chk("R3 trigger flag", int'(trg), 1);
      tick(1);
      chk("R3 counting resumes", int'(count), 1);
      clear_flags(2'b10);
      chk("R10 clear trigger flag", int'(trg), 0);
      itrig = 4'h0;
      src = 3'b111;
      tick(3);
      itrig = 4'hF;
      v = int'(count);
      tick(4);
      chk("R6 reserved source no restart", int'(count), v + 4);
      chk("R6 reserved source no flag", int'(trg), 0);
      itrig = 4'h0;
      tick(4);
      src = 3'b010;
      tick(4);
      v = int'(count);
      itrig = 4'b0100;
      tick(3);
      chk("R6 internal trigger 2 restart", int'(count), 0);
      itrig = 4'h0;
      pol = 2'b00; flt = '0;
      tick(3);
      clear_flags(2'b10);
   endtask

   task automatic t_pause();
      src = 3'b101; chan = 2'b00; mode = 3'b101;
      tick(3);
      v = int'(count);
      tick(4);
      chk("R4 held while trigger low", int'(count), v);
      chan[0] = 1'b1;
      tick(2);
      chk("R8 R4 still held", int'(count), v);
      tick(1);
      chk("R4 R8 counts after third edge", int'(count), v + 1);
      tick(2);
      chk("R4 counting while high", int'(count), v + 3);
      chk("R10 R4 trigger flag on rise", int'(trg), 1);
      v = int'(count);
      pol[0] = 1'b1;
      tick(3);
      chk("R7 inverted channel pauses", int'(count), v + 2);
      tick(3);
      chk("R7 stays paused", int'(count), v + 2);
      v = int'(count);
      chan[0] = 1'b0;
      tick(3);
      chk("R7 inverted low input counts", int'(count), v + 1);
      pol = 2'b00;
      tick(4);
      clear_flags(2'b10);
   endtask

   task automatic t_event();
      mode = 3'b110; src = 3'b110; chan = 2'b00;
      write_en(1'b0);
      tick(3);
      v = int'(count);
      tick(3);
      chk("R5 idle while disabled", int'(count), v);
      chan[1] = 1'b1;
      tick(2);
      chk("R5 enable not yet set", int'(en), 0);
      tick(1);
      chk("R5 rise sets enable", int'(en), 1);
      chk("R5 count unchanged on set", int'(count), v);
      tick(2);
      chk("R5 counting after enable", int'(count), v + 2);
      write_en(1'b0);
      v = int'(count);
      tick(2);
      chk("R5 write clears enable", int'(count), v);
      chan[1] = 1'b0;
      tick(4);
      clear_flags(2'b10);
   endtask

   task automatic t_filter();
      mode = 3'b100; src = 3'b101; flt = FW'(3); chan = 2'b00;
      write_en(1'b1);
      tick(6);
      clear_flags(2'b10);
      v = int'(count);
      chan[0] = 1'b1;
      tick(3);
      chan[0] = 1'b0;
      tick(8);
      chk("R9 short pulse rejected", int'(count), v + 11);
      chk("R9 no trigger flag", int'(trg), 0);
      v = int'(count);
      chan[0] = 1'b1;
      tick(6);
      chk("R9 not yet through filter", int'(count), v + 6);
      tick(1);
      chk("R9 held level restarts", int'(count), 0);
      chan[0] = 1'b0;
      tick(10);
   endtask

   task automatic t_edge();
      src = 3'b100; flt = '0; mode = 3'b100; chan = 2'b00;
      tick(4);
      clear_flags(2'b10);
      chan[0] = 1'b1;
      tick(3);
      chk("R6 edge source rising restart", int'(count), 0);
      tick(5);
      chk("R6 counting after edge", int'(count), 5);
      chan[0] = 1'b0;
      tick(2);
      chk("R6 before falling restart", int'(count), 7);
      tick(1);
      chk("R6 edge source falling restart", int'(count), 0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      t_reset();
      t_wrap();
      t_restart();
      t_pause();
      t_event();
      t_filter();
      t_edge();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   end
endmodule